// File: doc/BRIEF.md
# PWM Back-End Reset Sequencer

This block lives next to a PWM modulator and owns the active-low reset line of a switching power back end. At power-up the back end must sit in its high-impedance state, so the line is held low. It stays low while the bootstrap capacitors charge, and then until the modulator reports itself ready and the PWM stream it produces has been measured as a healthy switching signal. On shutdown the sequencer pulls the reset line low first. Only after that does it withdraw the PWM enable, so the stage never sees PWM vanish while it is still running.

The sequencer watches the PWM line it sends out, using the reference clock. A synchronizer feeds a rising-edge period meter, a stuck-high guard and a no-edge timeout. The stream counts as valid only after a run of consecutive periods that fall inside the allowed frequency window. The control flow is a six-state machine:

- **OFF**: the rest state.
- **CHARGE**: the timed bootstrap precharge.
- **WAIT_PWM**: PWM is enabled but the back end is still held in reset.
- **RUN**: reset is released.
- **STOP_RESET**: reset is re-asserted while PWM keeps running.
- **STOP_PWM**: PWM is withdrawn.

The state transitions are:

- OFF→CHARGE: gate supply good and no power-down request.
- CHARGE→WAIT_PWM: the timer expires.
- CHARGE→OFF: gate supply lost or power-down requested.
- WAIT_PWM→RUN: the modulator is ready, the stream is valid and no power-down is requested.
- WAIT_PWM→OFF: gate supply lost.
- WAIT_PWM→STOP_PWM: power-down requested.
- RUN→WAIT_PWM: the stream becomes invalid or the modulator drops ready.
- RUN→STOP_RESET: power-down requested or gate supply lost.
- STOP_RESET→STOP_PWM: always, after one cycle.
- STOP_PWM→OFF: always, after one cycle.

Top module: `bkend_rst_seq`

## Requirements
- R1: After `rst_n` is asserted, `be_rst_n` and `pwm_en` are both 0, and both stay 0 for as long as `gate_ok` is low.
- R2: When `gate_ok` goes high in OFF (with `pwr_down_req` low), the block spends exactly CHARGE_CYC cycles in CHARGE with `be_rst_n`=0 and `pwm_en`=0. `pwm_en` rises on the (CHARGE_CYC+1)-th rising clock edge after the first edge that samples `gate_ok` high.
- R3: `be_rst_n` rises only on the edge after one where `mod_ready`=1, `gate_ok`=1, `pwr_down_req`=0 and the stream is valid. If the stream is already valid when `mod_ready` rises, release happens on the very next edge.
- R4: The stream is valid only after GOOD_PERIODS consecutive rising-to-rising periods, each measured in reference cycles, lie within [ceil(REF_HZ/F_MAX_HZ), floor(REF_HZ/F_MIN_HZ)]. Any period outside that window, whether too short or too long, clears validity.
- R5: A PWM line that stays high for more than floor(REF_HZ/F_MIN_HZ) cycles is invalid. In RUN this drives `be_rst_n` low within a few cycles, while `pwm_en` stays 1.
- R6: A PWM line with no rising edge for TMO_PERIODS×floor(REF_HZ/F_MIN_HZ) cycles is invalid. In RUN this drives `be_rst_n` low, while `pwm_en` stays 1.
- R7: In RUN, loss of validity or of `mod_ready` drives `be_rst_n` low on the next edge and returns to WAIT_PWM with `pwm_en` kept at 1. Release then follows again with no new charge delay.
- R8: A power-down request in RUN drives `be_rst_n` low on the next edge, and `pwm_en` low exactly one edge later. `pwm_en` never falls while `be_rst_n` is high, nor in the cycle `be_rst_n` falls, and `be_rst_n` is never high while `pwm_en` is low.
- R9: Loss of `gate_ok` in RUN runs the same stop order as R8. Loss of `gate_ok` in CHARGE returns to OFF, so the next rise of `gate_ok` starts a full CHARGE_CYC charge again.
- R10: While `pwr_down_req` is held high, the block stays in OFF (`be_rst_n`=0, `pwm_en`=0) even with `gate_ok` high. Clearing the request starts a full charge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; period measurement counts its cycles |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| gate_ok | input | 1 | Gate-drive supply of the back end is present and good |
| mod_ready | input | 1 | Modulator is initialised and able to stream |
| pwr_down_req | input | 1 | Request to shut the back end down |
| pwm_in | input | 1 | The PWM line sent to the back end, looped back for monitoring (asynchronous) |
| be_rst_n | output | 1 | Active-low reset to the power back end |
| pwm_en | output | 1 | Permission for the modulator to drive switching PWM |

## Verification
The assertions take `gate_ok`, `mod_ready` and `pwr_down_req` to be synchronous to `clk`. They treat `pwm_in` as a free-running level that is only seen through the synchronizer, so the stuck-high property allows a fixed pipeline margin beyond the period limit. The stimulus changes every control input on the falling clock edge. It generates PWM as whole-cycle periods that switch only while `pwm_en` is high. It moves the period between 290, 330 and 380 cycles at a 125 MHz reference, so the window edges at 313 and 357 are crossed on both sides. Stuck-high and stuck-low streams are produced by freezing the generator in mid-stream rather than by glitching it.

// File: rtl/bkrs_pkg.sv
package bkrs_pkg;

    typedef enum logic [2:0] {
        SEQ_OFF,
        SEQ_CHARGE,
        SEQ_WAIT_PWM,
        SEQ_RUN,
        SEQ_STOP_RST,
        SEQ_STOP_PWM
    } seq_state_e;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/bkrs_sync.sv
module bkrs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= 1'b0;
                else        chain_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[i] <= 1'b0;
                else        chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bkrs_delay_timer.sv
module bkrs_delay_timer #(
    parameter int CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
    localparam logic [W-1:0] LAST_C = W'(CYCLES - 1);

    logic [W-1:0] cnt_q;

    assign done = run && (cnt_q == LAST_C);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run)   cnt_q <= '0;
        else if (!done)  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/bkrs_pwm_monitor.sv
module bkrs_pwm_monitor #(
    parameter int PER_MIN     = 125,
    parameter int PER_MAX     = 142,
    parameter int TMO_CYC     = 568,
    parameter int GOOD_N      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic pwm_in,
    output logic stream_ok
);
    localparam int CNT_W = $clog2(TMO_CYC + 1);
    localparam int HI_W  = $clog2(PER_MAX + 2);
    localparam int GD_W  = $clog2(GOOD_N + 1);

    localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(PER_MIN);
    localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(PER_MAX);
    localparam logic [CNT_W-1:0] TMO_C  = CNT_W'(TMO_CYC);
    localparam logic [HI_W-1:0]  HIMX_C = HI_W'(PER_MAX);
    localparam logic [GD_W-1:0]  GOOD_C = GD_W'(GOOD_N);

    logic             pwm_s;
    logic             pwm_d;
    logic             rise;
    logic [CNT_W-1:0] per_q;
    logic [HI_W-1:0]  hi_q;
    logic [GD_W-1:0]  good_q;
    logic             in_win;
    logic             timeout;
    logic             stuck_hi;

    bkrs_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pwm_in),
        .q     (pwm_s)
    );

    assign rise     = pwm_s && !pwm_d;
    assign in_win   = (per_q >= MIN_C) && (per_q <= MAX_C);
    assign timeout  = (per_q >= TMO_C);
    assign stuck_hi = (hi_q > HIMX_C);

    // edge tracker and period counter; a cleared counter starts saturated
    // so the first edge after enable never counts as a good period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_d <= 1'b0;
            per_q <= TMO_C;
        end else begin
            pwm_d <= pwm_s;
            if (clr)          per_q <= TMO_C;
            else if (rise)    per_q <= CNT_W'(1);
            else if (!timeout) per_q <= per_q + 1'b1;
        end
    end

    // high-level run length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              hi_q <= '0;
        else if (clr || !pwm_s)  hi_q <= '0;
        else if (!stuck_hi)      hi_q <= hi_q + 1'b1;
    end

    // consecutive good-period qualifier
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_q <= '0;
        end else if (clr || timeout || stuck_hi) begin
            good_q <= '0;
        end else if (rise) begin
            if (!in_win)              good_q <= '0;
            else if (good_q != GOOD_C) good_q <= good_q + 1'b1;
        end
    end

    assign stream_ok = (good_q == GOOD_C);
endmodule

// File: rtl/bkend_rst_seq.sv
module bkend_rst_seq
    import bkrs_pkg::*;
#(
    parameter int REF_HZ      = 50_000_000,
    parameter int F_MIN_HZ    = 350_000,
    parameter int F_MAX_HZ    = 400_000,
    parameter int CHARGE_CYC  = 50_000,
    parameter int TMO_PERIODS = 4,
    parameter int GOOD_PERIODS = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_ok,
    input  logic mod_ready,
    input  logic pwr_down_req,
    input  logic pwm_in,
    output logic be_rst_n,
    output logic pwm_en
);
    localparam int PER_MIN = int'(ceil_div(REF_HZ, F_MAX_HZ));
    localparam int PER_MAX = REF_HZ / F_MIN_HZ;
    localparam int TMO_CYC = TMO_PERIODS * PER_MAX;

    seq_state_e state_q;
    seq_state_e state_d;
    logic       charge_done;
    logic       stream_ok;
    logic       rst_out_q;
    logic       en_out_q;

    bkrs_delay_timer #(.CYCLES(CHARGE_CYC)) charge_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == SEQ_CHARGE),
        .done  (charge_done)
    );

    bkrs_pwm_monitor #(
        .PER_MIN     (PER_MIN),
        .PER_MAX     (PER_MAX),
        .TMO_CYC     (TMO_CYC),
        .GOOD_N      (GOOD_PERIODS),
        .SYNC_STAGES (SYNC_STAGES)
    ) mon_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!en_out_q),
        .pwm_in    (pwm_in),
        .stream_ok (stream_ok)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_OFF: begin
                if (gate_ok && !pwr_down_req) state_d = SEQ_CHARGE;
            end
            SEQ_CHARGE: begin
                if (!gate_ok || pwr_down_req) state_d = SEQ_OFF;
                else if (charge_done)         state_d = SEQ_WAIT_PWM;
            end
            SEQ_WAIT_PWM: begin
                if (!gate_ok)                   state_d = SEQ_OFF;
                else if (pwr_down_req)          state_d = SEQ_STOP_PWM;
                else if (mod_ready && stream_ok) state_d = SEQ_RUN;
            end
            SEQ_RUN: begin
                if (!gate_ok || pwr_down_req)    state_d = SEQ_STOP_RST;
                else if (!mod_ready || !stream_ok) state_d = SEQ_WAIT_PWM;
            end
            SEQ_STOP_RST: state_d = SEQ_STOP_PWM;
            SEQ_STOP_PWM: state_d = SEQ_OFF;
            default:      state_d = SEQ_OFF;
        endcase
    end

    // registered outputs, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_out_q <= 1'b0;
            en_out_q  <= 1'b0;
        end else begin
            rst_out_q <= (state_d == SEQ_RUN);
            en_out_q  <= (state_d == SEQ_WAIT_PWM) || (state_d == SEQ_RUN) ||
                         (state_d == SEQ_STOP_RST);
        end
    end

    assign be_rst_n = rst_out_q;
    assign pwm_en   = en_out_q;
endmodule

// File: rtl/bkrs_checker.sv
module bkrs_checker #(
    parameter int CHARGE_CYC  = 50_000,
    parameter int PER_MAX     = 142,
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic gate_ok,
    input logic mod_ready,
    input logic pwr_down_req,
    input logic pwm_in,
    input logic stream_ok,
    input logic be_rst_n,
    input logic pwm_en
);
    localparam int HI_LIM = PER_MAX + SYNC_STAGES + 6;
    localparam int GW     = $clog2(CHARGE_CYC + 1);
    localparam int HW     = $clog2(HI_LIM + 2);
    localparam logic [GW-1:0] GSAT_C = GW'(CHARGE_CYC);
    localparam logic [HW-1:0] HSAT_C = HW'(HI_LIM + 1);
    localparam logic [HW-1:0] HLIM_C = HW'(HI_LIM);

    logic [GW-1:0] gate_run_q;
    logic [HW-1:0] hi_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  gate_run_q <= '0;
        else if (!gate_ok)           gate_run_q <= '0;
        else if (gate_run_q != GSAT_C) gate_run_q <= gate_run_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 hi_run_q <= '0;
        else if (!pwm_in)           hi_run_q <= '0;
        else if (hi_run_q != HSAT_C) hi_run_q <= hi_run_q + 1'b1;
    end

    AST_EN_FALLS_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_en) |-> (!be_rst_n && $past(!be_rst_n)))
        else $error("pwm_en dropped before reset was low"); // R8

    AST_RUN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        be_rst_n |-> pwm_en)
        else $error("back end released without PWM enable"); // R8

    AST_RELEASE_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(be_rst_n) |-> $past(stream_ok))
        else $error("release without a valid stream"); // R3

    AST_RUN_INPUTS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        be_rst_n |-> $past(mod_ready && gate_ok && !pwr_down_req))
        else $error("reset high after modulator or supply loss"); // R7

    AST_CHARGE_ELAPSED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(be_rst_n) |-> (gate_run_q >= GSAT_C))
        else $error("release before the charge delay"); // R2

    AST_STUCK_HIGH_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_run_q > HLIM_C) |-> !be_rst_n)
        else $error("reset high during stuck-high PWM"); // R5

    AST_OFF_WITHOUT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_ok && $past(!gate_ok)) |=> !be_rst_n)
        else $error("reset high without gate supply"); // R1
endmodule

bind bkend_rst_seq bkrs_checker #(
    .CHARGE_CYC  (CHARGE_CYC),
    .PER_MAX     (PER_MAX),
    .SYNC_STAGES (SYNC_STAGES)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_ok      (gate_ok),
    .mod_ready    (mod_ready),
    .pwr_down_req (pwr_down_req),
    .pwm_in       (pwm_in),
    .stream_ok    (stream_ok),
    .be_rst_n     (be_rst_n),
    .pwm_en       (pwm_en)
);

// File: tb/bkend_rst_seq_tb.sv
module bkend_rst_seq_tb_top;
    localparam int REF_HZ = 125_000_000;
    localparam int CHG    = 3000;
    localparam int PMAX   = REF_HZ / 350_000;  // 357
    localparam int TMO    = 4 * PMAX;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic gate_ok = 1'b0;
    logic mod_ready = 1'b0;
    logic pwr_down_req = 1'b0;
    logic pwm_in = 1'b0;
    wire  be_rst_n;
    wire  pwm_en;

    int n_chk = 0;
    int n_fail = 0;
    int mode = 1;   // 0 low, 1 switching, 2 stuck high
    int per = 330;
    int pcnt = 0;

    bkend_rst_seq #(
        .REF_HZ     (REF_HZ),
        .CHARGE_CYC (CHG)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .gate_ok      (gate_ok),
        .mod_ready    (mod_ready),
        .pwr_down_req (pwr_down_req),
        .pwm_in       (pwm_in),
        .be_rst_n     (be_rst_n),
        .pwm_en       (pwm_en)
    );

    // modulator model: switches only while enabled
    always @(negedge clk) begin
        if (pwm_en !== 1'b1 || mode == 0) begin
            pcnt   <= 0;
            pwm_in <= 1'b0;
        end else if (mode == 2) begin
            pwm_in <= 1'b1;
        end else begin
            pcnt   <= (pcnt >= per - 1) ? 0 : pcnt + 1;
            pwm_in <= (pcnt < per / 2);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_rel(input int maxc, output int took);
        took = 0;
        while (be_rst_n !== 1'b1 && took < maxc) begin
            @(negedge clk);
            took++;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cycles(5);
        chk("R1 rst", be_rst_n, 0);
        chk("R1 en", pwm_en, 0);
        rst_n = 1'b1;
        cycles(500);
        chk("R1 rst gate low", be_rst_n, 0);
        chk("R1 en gate low", pwm_en, 0);
    endtask

    // from OFF: verifies exact charge length, then returns in WAIT_PWM
    task automatic t_charge(input string req);
        gate_ok = 1'b1;
        repeat (CHG - 1) @(posedge clk);
        @(negedge clk);
        chk({req, " en during charge"}, pwm_en, 0);
        chk({req, " rst during charge"}, be_rst_n, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk({req, " en after charge"}, pwm_en, 1);
    endtask

    task automatic t_release_gate();
        int took;
        mode = 1; per = 330;
        t_charge("R2");
        cycles(3000);
        chk("R3 held without mod_ready", be_rst_n, 0);
        mod_ready = 1'b1;
        wait_rel(200, took);
        chk("R3 release next edge", took, 1);
    endtask

    task automatic t_modready_drop();
        mod_ready = 1'b0;
        @(negedge clk);
        chk("R7 rst on mod_ready loss", be_rst_n, 0);
        chk("R7 en kept", pwm_en, 1);
        mod_ready = 1'b1;
        @(negedge clk);
        chk("R7 quick re-release", be_rst_n, 1);
    endtask

    task automatic t_stuck_high();
        int took;
        mode = 2;
        cycles(PMAX - 200);
        chk("R5 not yet stuck", be_rst_n, 1);
        cycles(220);
        chk("R5 rst on stuck high", be_rst_n, 0);
        chk("R5 en kept", pwm_en, 1);
        mode = 1;
        wait_rel(2500, took);
        chk("R7 re-release after stuck high", be_rst_n, 1);
        chk("R7 no new charge", int'(took < CHG), 1);
    endtask

    task automatic t_stuck_low();
        int took;
        mode = 0;
        cycles(TMO + 50);
        chk("R6 rst on no edges", be_rst_n, 0);
        chk("R6 en kept", pwm_en, 1);
        mode = 1;
        wait_rel(2500, took);
        chk("R6 recover", be_rst_n, 1);
    endtask

    task automatic t_power_down();
        int took;
        pwr_down_req = 1'b1;
        @(negedge clk);
        chk("R8 rst first", be_rst_n, 0);
        chk("R8 en still on", pwm_en, 1);
        @(negedge clk);
        chk("R8 en off next", pwm_en, 0);
        cycles(3500);
        chk("R10 en held off", pwm_en, 0);
        chk("R10 rst held low", be_rst_n, 0);
        pwr_down_req = 1'b0;
        gate_ok = 1'b0;
        @(negedge clk);
        t_charge("R10");
        wait_rel(3000, took);
        chk("R10 release after restart", be_rst_n, 1);
    endtask

    task automatic t_freq_window();
        int took;
        gate_ok = 1'b0;
        @(negedge clk);
        chk("R9 rst on gate loss", be_rst_n, 0);
        chk("R9 en one more cycle", pwm_en, 1);
        @(negedge clk);
        chk("R9 en off", pwm_en, 0);
        @(negedge clk);
        per = 290;
        gate_ok = 1'b1;
        cycles(CHG + 3000);
        chk("R4 period too short", be_rst_n, 0);
        per = 380;
        cycles(3000);
        chk("R4 period too long", be_rst_n, 0);
        per = 330;
        wait_rel(3000, took);
        chk("R4 period in window", be_rst_n, 1);
    endtask

    task automatic t_gate_glitch_charge();
        gate_ok = 1'b0;
        cycles(3);
        gate_ok = 1'b1;
        cycles(1000);
        gate_ok = 1'b0;
        @(negedge clk);
        @(negedge clk);
        t_charge("R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        t_reset();
        t_release_gate();
        t_modready_drop();
        t_stuck_high();
        t_stuck_low();
        t_power_down();
        t_freq_window();
        t_gate_glitch_charge();
        summary();
    end
endmodule